// File: doc/BRIEF.md
# Borrow-Chain Round-Robin Arbiter

This block shares one resource among a parameter number of requestors in rotating order. It holds a one-hot pointer that marks the requestor currently first in line. Each cycle it forms a double-width copy of the request vector, subtracts the pointer from it, and ANDs the copy with the inverted difference. The borrow runs upward from the pointer through every clear request bit and stops at the first set one, so that bit alone survives. ORing the two halves of the result folds a hit past the top bit back onto the low positions, which gives the wrap-around.

The grant is combinational from the request and the stored pointer, so a requestor sees its grant in the same cycle it raises its request. On each clock edge where a grant was issued, the pointer moves to the position just above the winner, with the top position wrapping to bit 0. In a cycle with no request the pointer keeps its value. The pointer logic is a two-action state machine. HOLD keeps the pointer and is taken when the grant is zero. ADVANCE loads the rotated winner and is taken when the grant is non-zero. Reset puts the pointer at bit 0.

Top module: `rr_sub_arbiter`

## Requirements
- R1: The grant output has at most one bit set in every cycle.
- R2: The grant is all zeros exactly when the request vector is all zeros.
- R3: Every set grant bit corresponds to a set request bit.
- R4: After reset the pointer is at bit 0, so the first grant goes to the lowest-indexed active request.
- R5: The grant goes to the first set request bit found by scanning upward from the pointer position, wrapping from the top bit to bit 0. Clear bits are skipped. With request 1001 and the pointer at bit 1, the grant is 1000.
- R6: After a cycle with a non-zero grant, the pointer equals that grant rotated left by one position, with the top bit moving to bit 0.
- R7: A cycle with no request leaves the pointer unchanged.
- R8: With all requests held high, successive grants visit bits 0, 1, ..., WIDTH-1 in order and then repeat.
- R9: Asserting reset while arbitration is in progress returns the pointer to bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | WIDTH | One bit per requestor, high while it wants the resource |
| gnt_o | output | WIDTH | One-hot grant, zero when nothing is requested |

## Verification
The pointer is the only state in this block. Because the grant is computed combinationally from it, a wrong pointer shows up at the grant port in the very next cycle in which two or more requests are active. A single request hides a wrong pointer, since it wins from any pointer position. For that reason, the directed scenarios hold several requests at once after every pointer move, including idle gaps and resets in the middle of a run. Each grant is compared against an independent scan model in the same cycle.

// File: rtl/rr_sub_pkg.sv
package rr_sub_pkg;

    // Action taken by the pointer register on the next edge.
    typedef enum logic {
        PTR_HOLD    = 1'b0,
        PTR_ADVANCE = 1'b1
    } ptr_act_e;

endpackage

// File: rtl/rr_sub_pick.sv
module rr_sub_pick #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] req,
    input  logic [WIDTH-1:0] base,
    output logic [WIDTH-1:0] gnt
);
    localparam int DW = 2 * WIDTH;

    logic [DW-1:0] dbl_req;
    logic [DW-1:0] base_ext;
    logic [DW-1:0] diff;
    logic [DW-1:0] hit;

    always_comb begin
        dbl_req  = {req, req};
        base_ext = {{WIDTH{1'b0}}, base};
        // Borrow ripples upward from the pointer through clear bits and
        // is absorbed by the first set bit; that bit alone survives.
        diff     = dbl_req - base_ext;
        hit      = dbl_req & ~diff;
        // Fold a hit in the upper copy back onto its low position.
        gnt      = hit[WIDTH-1:0] | hit[DW-1:WIDTH];
    end

endmodule

// File: rtl/rr_sub_base_reg.sv
module rr_sub_base_reg
    import rr_sub_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] gnt,
    output logic [WIDTH-1:0] base
);
    localparam logic [WIDTH-1:0] BASE_RST = WIDTH'(1);

    ptr_act_e         act;
    logic [WIDTH-1:0] base_q;
    logic [WIDTH-1:0] base_d;

    always_comb begin
        act = (|gnt) ? PTR_ADVANCE : PTR_HOLD;
        unique case (act)
            PTR_HOLD:    base_d = base_q;
            PTR_ADVANCE: base_d = {gnt[WIDTH-2:0], gnt[WIDTH-1]};
            default:     base_d = base_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= BASE_RST;
        end else begin
            base_q <= base_d;
        end
    end

    assign base = base_q;

    // The pointer always marks exactly one position.
    assert_base_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(base_q))
        else $error("pointer not one-hot");

    // An idle cycle leaves the pointer where it was.
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0) |=> $stable(base_q))
        else $error("pointer moved on idle cycle");

endmodule

// File: rtl/rr_sub_arbiter.sv
module rr_sub_arbiter #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] req_i,
    output logic [WIDTH-1:0] gnt_o
);
    logic [WIDTH-1:0] base;

    rr_sub_pick #(.WIDTH(WIDTH)) pick_i (
        .req  (req_i),
        .base (base),
        .gnt  (gnt_o)
    );

    rr_sub_base_reg #(.WIDTH(WIDTH)) ptr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .gnt   (gnt_o),
        .base  (base)
    );

    assert_gnt_onehot0_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o))
        else $error("grant has more than one bit");

    assert_gnt_when_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i != '0) |-> (gnt_o != '0))
        else $error("request pending but no grant");

    assert_gnt_in_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o & ~req_i) == '0)
        else $error("grant to idle requestor");

    assert_ptr_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0) |=> base == {$past(gnt_o[WIDTH-2:0]), $past(gnt_o[WIDTH-1])})
        else $error("pointer not at rotated winner");

endmodule

// File: tb/rr_sub_arbiter_tb_top.sv
module rr_sub_arbiter_tb_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] req = '0;
    logic [W-1:0] gnt;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [W-1:0] mbase = W'(1);

    always #10 clk = ~clk;   // 50 MHz

    rr_sub_arbiter #(.WIDTH(W)) dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req),
        .gnt_o (gnt)
    );

    function automatic logic [W-1:0] model(input logic [W-1:0] r, input logic [W-1:0] b);
        int s = 0;
        for (int i = 0; i < W; i++) if (b[i]) s = i;
        for (int k = 0; k < W; k++) begin
            int idx = (s + k) % W;
            if (r[idx]) return W'(1) << idx;
        end
        return '0;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive a request on the falling edge, check the grant mid-cycle,
    // then advance the pointer model as the next rising edge will.
    task automatic apply(input logic [W-1:0] r, input string tag);
        logic [W-1:0] e;
        @(negedge clk);
        req = r;
        #2;
        e = model(r, mbase);
        check(tag, gnt, e);
        if (e != '0) mbase = {e[W-2:0], e[W-1]};
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0;
        req = '0;
        mbase = W'(1);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R2 idle after reset", gnt, '0);
        apply(4'b1111, "R4 first grant after reset");
        check("R4 lowest bit wins", gnt, 4'b0001);
    endtask

    task automatic t_example;
        t_reset();
        apply(4'b0001, "R5 set pointer to bit1");
        apply(4'b1001, "R5 skip clear bits");
        check("R5 example 1001 from bit1", gnt, 4'b1000);
        apply(4'b0011, "R6 pointer wrapped to bit0");
        check("R6 rotated from top", gnt, 4'b0001);
    endtask

    task automatic t_rotate;
        t_reset();
        for (int k = 1; k < 2 * W; k++) begin
            apply(4'b1111, "R8 all held");
            check("R8 order", gnt, W'(1) << (k % W));
        end
    endtask

    task automatic t_idle;
        t_reset();
        apply(4'b0100, "R6 grant bit2");
        repeat (3) apply(4'b0000, "R7 idle no grant");
        apply(4'b1111, "R7 pointer kept at bit3");
        check("R7 resume at bit3", gnt, 4'b1000);
    endtask

    task automatic t_patterns;
        t_reset();
        apply(4'b1010, "R5 sparse a");
        apply(4'b1010, "R5 sparse b");
        apply(4'b1010, "R5 sparse c");
        apply(4'b0110, "R3 subset");
        apply(4'b0001, "R5 single");
        apply(4'b1100, "R5 wrap search");
        apply(4'b0101, "R5 wrap to low");
    endtask

    task automatic t_midreset;
        t_reset();
        apply(4'b1111, "R9 run a");
        apply(4'b1111, "R9 run b");
        @(negedge clk);
        rst_n = 1'b0;
        req = '0;
        mbase = W'(1);
        @(negedge clk);
        rst_n = 1'b1;
        apply(4'b1110, "R9 after mid reset");
        check("R9 pointer back at bit0", gnt, 4'b0010);
    endtask

    initial begin
        t_reset();
        t_example();
        t_rotate();
        t_idle();
        t_patterns();
        t_midreset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule